// File: doc/BRIEF.md
# BCD Calendar Clock with Host Shadow Registers

This block keeps time of day and calendar in packed BCD: seconds, minutes, hours in 24-hour form, day of week, date, month, two-digit year and century. A one-cycle pulse on the tick input, arriving once per second, advances a chain of internal counters. Month lengths are applied automatically, including a leap February for every year whose BCD value is a multiple of four. That rule is correct through the year 2099.

The host never touches the running counters directly. It sees a bank of byte registers that take a copy of the counters one cycle after each tick. Two bits of a control byte stop that copy. The read-hold bit gives the host a coherent snapshot while the counters keep running. The write-hold bit also stops the copy, so the host can fill in a new time. Clearing the write-hold bit with a control write moves the bytes the host wrote into the counters. The remaining six control bits are a calibration value that is stored and read back but has no effect. Other blocks take the live time from dedicated output ports.

Top module: `bcd_cal_clock`

## Requirements
- R1: After reset the counters and the visible bytes hold 00:00:00, day of week 01, date 01, month 01, year 00 and century 20, and the control byte reads 00.
- R2: Each tick adds one second. Seconds and minutes wrap from 59 to 00 and carry into the next field. Hours wrap from 23 to 00 and advance both the date and the day of week.
- R3: Day of week counts 1 to 7, and 7 wraps to 1.
- R4: The date wraps to 01 after 30 in months 04, 06, 09 and 11, and after 31 in the other months except February. February ends at 29 when the BCD year is divisible by 4 (year 00 included) and at 28 otherwise.
- R5: Month wraps from 12 to 01 and advances the year. Year wraps from 99 to 00 and advances the century.
- R6: The register window is selected when every address bit above bit 3 is 1. Within it, offset 0x1 is the century, 0x8 is control, and 0x9 to 0xF are second, minute, hour, day of week, date, month and year, in that order. rdata_o is 00 whenever rd_i is low.
- R7: While control bits 7 and 6 are both 0, the visible clock bytes take the counter values on the clock edge after each tick.
- R8: While control bit 6 is 1, the visible clock bytes keep their values and the time outputs keep advancing.
- R9: While control bit 7 is 1, the visible bytes stop refreshing and accept host writes. A control write with bit 7 at 0 while bit 7 is set loads all eight visible bytes into the counters at that edge. A tick on that same edge is dropped.
- R10: Control bits 5:0 are stored and read back unchanged, and they have no effect on the count.
- R11: Offsets 0x0 and 0x2 to 0x7, and every address outside the window, read as 00 and ignore writes.
- R12: A clock-byte write while both hold bits are 0 changes only the visible byte. The counters are untouched, and the next refresh overwrites the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse per second |
| addr_i | input | ADDR_W | Byte address |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational |
| sec_o | output | 8 | Live seconds, BCD |
| min_o | output | 8 | Live minutes, BCD |
| hour_o | output | 8 | Live hours, BCD |
| dow_o | output | 8 | Live day of week, BCD |
| date_o | output | 8 | Live date, BCD |
| mon_o | output | 8 | Live month, BCD |
| year_o | output | 8 | Live year, BCD |
| cent_o | output | 8 | Live century, BCD |

## Verification
The assertions check on every cycle that each live field stays inside its BCD range. They also check that the counters move only on a tick or a load, that a load copies the visible bytes exactly, and that the visible bytes hold while a hold bit is set and no clock-byte write arrives. Only the bench scenarios can show the calendar edges. These are the February length for leap and common years, the 30-day months and the year and century rollover. The scenarios also cover the release of the write hold, the placement of fields in the address map, and the overwrite of an unheld clock-byte write by the next refresh.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned NF     = 8;
  localparam int unsigned F_SEC  = 0;
  localparam int unsigned F_MIN  = 1;
  localparam int unsigned F_HOUR = 2;
  localparam int unsigned F_DOW  = 3;
  localparam int unsigned F_DATE = 4;
  localparam int unsigned F_MON  = 5;
  localparam int unsigned F_YEAR = 6;
  localparam int unsigned F_CENT = 7;
  localparam logic [3:0]  OFF_CTRL = 4'h8;

  typedef logic [7:0] bcd_t;

  function automatic bcd_t bcd_inc(bcd_t v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // tens digit weighs 10 = 2 (mod 4)
  function automatic logic is_leap(bcd_t yr);
    logic [4:0] s;
    s = {yr[7:4], 1'b0} + {1'b0, yr[3:0]};
    return (s[1:0] == 2'd0);
  endfunction

  function automatic bcd_t month_last(bcd_t mon, logic leap);
    case (mon)
      8'h02:                      return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  function automatic bcd_t fld_min(int unsigned f);
    case (f)
      F_DOW, F_DATE, F_MON: return 8'h01;
      default:              return 8'h00;
    endcase
  endfunction

  function automatic bcd_t fld_rst(int unsigned f, bcd_t cent);
    if (f == F_CENT) return cent;
    return fld_min(f);
  endfunction

  function automatic logic off_is_clk(logic [3:0] off);
    return (off == 4'h1) || (off >= 4'h9);
  endfunction

  function automatic logic [2:0] off_field(logic [3:0] off);
    if (off == 4'h1) return 3'(F_CENT);
    return 3'(off - 4'h9);
  endfunction
endpackage

// File: rtl/rtc_bcd_cnt.sv
module rtc_bcd_cnt
  import rtc_pkg::*;
#(
  parameter bcd_t MIN_VAL = 8'h00,
  parameter bcd_t RST_VAL = 8'h00
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic inc_i,
  input  logic load_i,
  input  bcd_t load_val_i,
  input  bcd_t max_i,
  output bcd_t cnt_o,
  output logic at_max_o
);
  bcd_t cnt_q;

  assign at_max_o = (cnt_q == max_i);
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= RST_VAL;
    else if (load_i) cnt_q <= load_val_i;
    else if (inc_i)  cnt_q <= at_max_o ? MIN_VAL : bcd_inc(cnt_q);
  end
endmodule

// File: rtl/rtc_time_core.sv
module rtc_time_core
  import rtc_pkg::*;
#(
  parameter bcd_t RST_CENTURY = 8'h20,
  localparam int unsigned VW  = NF * 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          load_i,
  input  logic [VW-1:0] load_val_i,
  output logic [VW-1:0] time_o
);
  logic [NF-1:0] inc, at_max;
  logic [VW-1:0] max_vec;
  logic t_sec, t_min, t_hour, t_day, t_mon, t_year, t_cent;

  always_comb begin
    t_sec  = tick_i & ~load_i;
    t_min  = t_sec  & at_max[F_SEC];
    t_hour = t_min  & at_max[F_MIN];
    t_day  = t_hour & at_max[F_HOUR];
    t_mon  = t_day  & at_max[F_DATE];
    t_year = t_mon  & at_max[F_MON];
    t_cent = t_year & at_max[F_YEAR];
    inc    = {t_cent, t_year, t_mon, t_day, t_day, t_hour, t_min, t_sec};
  end

  always_comb begin
    max_vec = '0;
    max_vec[F_SEC*8  +: 8] = 8'h59;
    max_vec[F_MIN*8  +: 8] = 8'h59;
    max_vec[F_HOUR*8 +: 8] = 8'h23;
    max_vec[F_DOW*8  +: 8] = 8'h07;
    max_vec[F_DATE*8 +: 8] = month_last(time_o[F_MON*8 +: 8],
                                        is_leap(time_o[F_YEAR*8 +: 8]));
    max_vec[F_MON*8  +: 8] = 8'h12;
    max_vec[F_YEAR*8 +: 8] = 8'h99;
    max_vec[F_CENT*8 +: 8] = 8'h99;
  end

  for (genvar i = 0; i < NF; i++) begin : g_fld
    rtc_bcd_cnt #(
      .MIN_VAL(fld_min(i)),
      .RST_VAL(fld_rst(i, RST_CENTURY))
    ) u_cnt (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .inc_i      (inc[i]),
      .load_i     (load_i),
      .load_val_i (load_val_i[i*8 +: 8]),
      .max_i      (max_vec[i*8 +: 8]),
      .cnt_o      (time_o[i*8 +: 8]),
      .at_max_o   (at_max[i])
    );
  end
endmodule

// File: rtl/rtc_shadow_regs.sv
module rtc_shadow_regs
  import rtc_pkg::*;
#(
  parameter bcd_t RST_CENTURY = 8'h20,
  localparam int unsigned VW  = NF * 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_win_i,
  input  logic [3:0]    off_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [7:0]    wdata_i,
  input  logic          refresh_i,
  input  logic [VW-1:0] time_i,
  output logic [7:0]    rdata_o,
  output logic [VW-1:0] shadow_o,
  output logic          load_o,
  output logic          frozen_o,
  output logic          clk_wr_o
);
  logic [7:0] ctrl_q;
  logic       ctrl_wr;
  logic [2:0] fsel;

  assign fsel     = off_field(off_i);
  assign ctrl_wr  = wr_i & in_win_i & (off_i == OFF_CTRL);
  assign clk_wr_o = wr_i & in_win_i & off_is_clk(off_i);
  assign frozen_o = ctrl_q[7] | ctrl_q[6];
  assign load_o   = ctrl_wr & ctrl_q[7] & ~wdata_i[7];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= 8'h00;
    else if (ctrl_wr) ctrl_q <= wdata_i;
  end

  for (genvar i = 0; i < NF; i++) begin : g_sh
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        shadow_o[i*8 +: 8] <= fld_rst(i, RST_CENTURY);
      else if (clk_wr_o && fsel == 3'(i))
        shadow_o[i*8 +: 8] <= wdata_i;
      else if (refresh_i && !frozen_o)
        shadow_o[i*8 +: 8] <= time_i[i*8 +: 8];
    end
  end

  always_comb begin
    rdata_o = 8'h00;
    if (rd_i && in_win_i) begin
      if (off_i == OFF_CTRL)     rdata_o = ctrl_q;
      else if (off_is_clk(off_i)) rdata_o = shadow_o[fsel*8 +: 8];
    end
  end
endmodule

// File: rtl/bcd_cal_clock.sv
module bcd_cal_clock
  import rtc_pkg::*;
#(
  parameter int unsigned ADDR_W      = 15,
  parameter bcd_t        RST_CENTURY = 8'h20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic [7:0]        sec_o,
  output logic [7:0]        min_o,
  output logic [7:0]        hour_o,
  output logic [7:0]        dow_o,
  output logic [7:0]        date_o,
  output logic [7:0]        mon_o,
  output logic [7:0]        year_o,
  output logic [7:0]        cent_o
);
  localparam int unsigned VW = NF * 8;

  logic          in_win, tick_q, load, frozen, clk_wr;
  logic [VW-1:0] time_vec, shadow_vec;

  assign in_win = &addr_i[ADDR_W-1:4];

  // refresh one edge after the counters move
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tick_q <= 1'b0;
    else         tick_q <= tick_i & ~load;
  end

  rtc_shadow_regs #(.RST_CENTURY(RST_CENTURY)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .in_win_i  (in_win),
    .off_i     (addr_i[3:0]),
    .wr_i      (wr_i),
    .rd_i      (rd_i),
    .wdata_i   (wdata_i),
    .refresh_i (tick_q),
    .time_i    (time_vec),
    .rdata_o   (rdata_o),
    .shadow_o  (shadow_vec),
    .load_o    (load),
    .frozen_o  (frozen),
    .clk_wr_o  (clk_wr)
  );

  rtc_time_core #(.RST_CENTURY(RST_CENTURY)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .load_i     (load),
    .load_val_i (shadow_vec),
    .time_o     (time_vec)
  );

  assign sec_o  = time_vec[F_SEC*8  +: 8];
  assign min_o  = time_vec[F_MIN*8  +: 8];
  assign hour_o = time_vec[F_HOUR*8 +: 8];
  assign dow_o  = time_vec[F_DOW*8  +: 8];
  assign date_o = time_vec[F_DATE*8 +: 8];
  assign mon_o  = time_vec[F_MON*8  +: 8];
  assign year_o = time_vec[F_YEAR*8 +: 8];
  assign cent_o = time_vec[F_CENT*8 +: 8];
endmodule

// File: rtl/bcd_cal_clock_chk.sv
module bcd_cal_clock_chk
  import rtc_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic          tick_i,
  input logic          load_i,
  input logic          frozen_i,
  input logic          clk_wr_i,
  input logic [NF*8-1:0] time_i,
  input logic [NF*8-1:0] shadow_i
);
  // R2
  sec_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    time_i[3:0] <= 4'd9 && time_i[7:0] <= 8'h59);
  // R2
  hour_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    time_i[F_HOUR*8 +: 4] <= 4'd9 && time_i[F_HOUR*8 +: 8] <= 8'h23);
  // R3
  dow_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    time_i[F_DOW*8 +: 8] >= 8'h01 && time_i[F_DOW*8 +: 8] <= 8'h07);
  // R4
  date_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    time_i[F_DATE*8 +: 8] >= 8'h01 && time_i[F_DATE*8 +: 8] <= 8'h31);
  // R5
  mon_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    time_i[F_MON*8 +: 8] >= 8'h01 && time_i[F_MON*8 +: 8] <= 8'h12);
  // R2
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !load_i) |=> $stable(time_i));
  // R9
  load_copy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (time_i == $past(shadow_i)));
  // R8
  freeze_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frozen_i && !clk_wr_i) |=> $stable(shadow_i));
endmodule

bind bcd_cal_clock bcd_cal_clock_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .tick_i   (tick_i),
  .load_i   (load),
  .frozen_i (frozen),
  .clk_wr_i (clk_wr),
  .time_i   (time_vec),
  .shadow_i (shadow_vec)
);

// File: tb/bcd_cal_clock_bench.sv
`timescale 1ns/100ps
module bcd_cal_clock_bench;
  localparam int AW = 15;

  typedef struct {
    logic [3:0] off;
    logic [7:0] exp;
    string      tag;
  } rd_item_t;

  logic clk_i = 1'b0, rst_ni = 1'b0, tick_i = 1'b0, wr_i = 1'b0, rd_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [7:0] wdata_i = '0, rdata_o;
  logic [7:0] sec_o, min_o, hour_o, dow_o, date_o, mon_o, year_o, cent_o;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  rd_item_t sb[$];

  always #2.5 clk_i = ~clk_i;

  bcd_cal_clock u_bcd_cal_clock (.*);

  function automatic logic [AW-1:0] win(logic [3:0] off);
    return {{(AW-4){1'b1}}, off};
  endfunction

  // scoreboard monitor
  always @(negedge clk_i) begin
    if (rd_i && sb.size() > 0) begin
      rd_item_t it;
      it = sb.pop_front();
      n_cmp++;
      if (rdata_o !== it.exp) begin
        n_bad++;
        $display("FAIL %s off %h: got %h exp %h", it.tag, it.off, rdata_o, it.exp);
      end
    end
  end

  task automatic rd(input logic [AW-1:0] a, input logic [7:0] exp, input string tag);
    rd_item_t it;
    it.off = a[3:0]; it.exp = exp; it.tag = tag;
    @(posedge clk_i); #1;
    sb.push_back(it);
    addr_i = a; rd_i = 1'b1;
    @(posedge clk_i); #1;
    rd_i = 1'b0;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(posedge clk_i); #1;
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(posedge clk_i); #1;
    wr_i = 1'b0;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk_i); #1 tick_i = 1'b1;
      @(posedge clk_i); #1 tick_i = 1'b0;
    end
  endtask

  task automatic chk_time(input logic [63:0] exp, input string tag);
    @(negedge clk_i);
    n_cmp++;
    if ({cent_o, year_o, mon_o, date_o, dow_o, hour_o, min_o, sec_o} !== exp) begin
      n_bad++;
      $display("FAIL %s time: got %h exp %h", tag,
               {cent_o, year_o, mon_o, date_o, dow_o, hour_o, min_o, sec_o}, exp);
    end
  endtask

  task automatic chk_byte(input logic [7:0] got, input logic [7:0] exp, input string tag);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic set_time(input logic [63:0] t);
    wr(win(4'h8), 8'h80);
    wr(win(4'h1), t[63:56]);
    wr(win(4'hF), t[55:48]);
    wr(win(4'hE), t[47:40]);
    wr(win(4'hD), t[39:32]);
    wr(win(4'hC), t[31:24]);
    wr(win(4'hB), t[23:16]);
    wr(win(4'hA), t[15:8]);
    wr(win(4'h9), t[7:0]);
    wr(win(4'h8), 8'h00);
  endtask

  task automatic summary;
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout exp completion");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;

    // R1 reset state, R6 map
    chk_time(64'h20000101_01000000, "R1");
    rd(win(4'h1), 8'h20, "R1 R6 century");
    rd(win(4'h8), 8'h00, "R1 ctrl");
    rd(win(4'h9), 8'h00, "R6 sec");
    rd(win(4'hC), 8'h01, "R6 dow");
    rd(win(4'hE), 8'h01, "R6 month");
    @(negedge clk_i); addr_i = win(4'h1);
    #0.1 chk_byte(rdata_o, 8'h00, "R6 idle rdata");

    // R2 R7 seconds advance and refresh
    tick(3);
    chk_time(64'h20000101_01000003, "R2");
    rd(win(4'h9), 8'h03, "R7 refresh");

    // R2 R3 R4 common February, dow wrap
    set_time(64'h20230228_07235959);
    chk_time(64'h20230228_07235959, "R9 load");
    tick(1);
    chk_time(64'h20230301_01000000, "R2 R3 R4 feb28");
    rd(win(4'hD), 8'h01, "R4 date byte");
    rd(win(4'hB), 8'h00, "R6 hour byte");

    // R4 leap year
    set_time(64'h20240228_03235959);
    tick(1);
    chk_time(64'h20240229_04000000, "R4 leap29");
    set_time(64'h20240229_04235959);
    tick(1);
    chk_time(64'h20240301_05000000, "R4 leap end");
    set_time(64'h20000228_01235959);
    tick(1);
    chk_time(64'h20000229_02000000, "R4 year00 leap");

    // R4 30/31 day months
    set_time(64'h20250430_02235959);
    tick(1);
    chk_time(64'h20250501_03000000, "R4 april");
    set_time(64'h20250130_02235959);
    tick(1);
    chk_time(64'h20250131_03000000, "R4 jan31");

    // R5 year and century rollover
    set_time(64'h20991231_06235959);
    tick(1);
    chk_time(64'h21000101_07000000, "R5 rollover");
    rd(win(4'h1), 8'h21, "R5 century byte");
    rd(win(4'hF), 8'h00, "R5 year byte");

    // R8 read hold
    wr(win(4'h8), 8'h40);
    tick(2);
    chk_time(64'h21000101_07000002, "R8 live");
    rd(win(4'h9), 8'h00, "R8 held");
    rd(win(4'h8), 8'h40, "R8 ctrl");
    wr(win(4'h8), 8'h00);
    tick(1);
    rd(win(4'h9), 8'h03, "R7 after release");

    // R9 write hold and load
    wr(win(4'h8), 8'h80);
    wr(win(4'h9), 8'h30);
    tick(1);
    rd(win(4'h9), 8'h30, "R9 held write");
    chk_time(64'h21000101_07000004, "R9 counters run");
    wr(win(4'h8), 8'h00);
    chk_time(64'h21000101_07000030, "R9 loaded");

    // R10 calibration field
    wr(win(4'h8), 8'h15);
    rd(win(4'h8), 8'h15, "R10 readback");
    tick(1);
    chk_time(64'h21000101_07000031, "R10 no effect");
    rd(win(4'h9), 8'h31, "R10 refresh");

    // R11 unused offsets and outside window
    wr(win(4'h3), 8'h55);
    rd(win(4'h3), 8'h00, "R11 reserved");
    rd(win(4'h0), 8'h00, "R11 offset0");
    wr(15'h0009, 8'h44);
    rd(win(4'h9), 8'h31, "R11 outside write");
    rd(15'h0009, 8'h00, "R11 outside read");

    // R12 unheld write overwritten by refresh
    wr(win(4'h9), 8'h45);
    rd(win(4'h9), 8'h45, "R12 written");
    chk_time(64'h21000101_07000031, "R12 counters");
    tick(1);
    rd(win(4'h9), 8'h32, "R12 overwritten");

    repeat (3) @(posedge clk_i);
    if (sb.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL scoreboard: got %0d left exp 0", sb.size());
    end
    summary();
  end
endmodule